// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host side of a two-wire debug link. Each transaction is started by a single `start_i` pulse. The block then sends an 8-bit request header on the data wire and hands the wire over to the target. It reads back a 3-bit acknowledge and branches on that value:

- On an OK acknowledge it runs a 33-bit read or write data phase. After that phase it adds a per-transfer number of idle clocks with the wire released.
- On a WAIT acknowledge it gives two released clocks.
- On any other acknowledge it stops at once and reports a fault.

The bit rate is set by the parameter `HALF_DIV`, the number of system clocks in each half of a link clock. Line reset, retries and register-level sequencing belong to a higher layer.

The controller is one state machine with ten named states:

- `S_IDLE`: the only state that accepts a start.
- `S_HEADER`: eight header slots.
- `S_TURN_IN`: one released turnaround slot.
- `S_ACK_IN`: three acknowledge slots.
- `S_READ_DATA`: 32 data slots plus a parity slot.
- `S_TURN_OUT`: two released slots before a write.
- `S_WRITE_DATA`: 32 data slots plus a parity slot.
- `S_WAIT_IDLE`: two released slots after WAIT.
- `S_TRAILING`: the requested idle slots.
- `S_FINISH`: a one-cycle completion state.

Transitions:

- `S_IDLE`→`S_HEADER` when `start_i` is high.
- `S_HEADER`→`S_TURN_IN` after slot 7.
- `S_TURN_IN`→`S_ACK_IN`.
- `S_ACK_IN` after its third slot:
  - to `S_READ_DATA` on OK with a read request;
  - to `S_TURN_OUT` on OK with a write request;
  - to `S_WAIT_IDLE` on WAIT;
  - to `S_FINISH` otherwise.
- `S_TURN_OUT`→`S_WRITE_DATA` after two slots.
- `S_READ_DATA` and `S_WRITE_DATA` after slot 32: to `S_TRAILING`, or straight to `S_FINISH` when the count is zero.
- `S_TRAILING`→`S_FINISH` after the last idle slot.
- `S_WAIT_IDLE`→`S_FINISH` after two slots.
- `S_FINISH`→`S_IDLE`.

Top module: `swd_xfer_engine`

## Requirements
- R1: After reset `swclk_o`, `swdio_oe`, `busy_o` and `done_o` are all 0. `swclk_o` and `swdio_oe` stay 0 while no transaction runs.
- R2: Each bit slot lasts 2*HALF_DIV clocks. The link clock is low for the first HALF_DIV clocks and high for the rest. `swdio_o` and `swdio_oe` change only while the link clock is low. `swdio_i` is taken on the low-to-high transition of the link clock.
- R3: The header occupies 8 driven slots (`swdio_oe`=1). In time order they carry: 1, `req_i[0]` (AP/DP select), `req_i[1]` (1 = read), `req_i[2]`, `req_i[3]`, the XOR of `req_i[3:0]`, 0, 1.
- R4: After the header there is one released slot, then three released acknowledge slots. The first acknowledge bit taken becomes `ack_o[2]` and the last becomes `ack_o[0]`.
- R5: For an OK acknowledge (`ack_o`=3'b001) on a read, 33 released slots follow. The first 32 fill `rdata_o` from bit 0 upward. `parity_err_o` is 1 exactly when the 33rd bit differs from the XOR of the 32 bits received.
- R6: For an OK acknowledge on a write, two released slots follow. Then come 33 driven slots: `wdata_i` from bit 0 upward, then the XOR of all 32 data bits.
- R7: After an OK data phase the engine gives exactly `trail_i` released idle slots, sampled at start; a count of 0 gives none.
- R8: An acknowledge of 3'b010 (WAIT) gives two released slots, with no data phase and no idle slots. It ends with `status_o`=2'd1.
- R9: Any acknowledge other than 3'b001 and 3'b010 ends the transaction right after the third acknowledge slot with `status_o`=2'd2 (FAULT). An OK transaction ends with `status_o`=2'd0.
- R10: `start_i` is accepted only when the engine is idle. `busy_o` is 1 from the clock after acceptance until completion. `done_o` is a one-clock pulse with `busy_o`=0, and the results are valid during that pulse. A `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a transaction (taken when idle) |
| req_i | input | 4 | Request fields: [0] AP/DP, [1] read, [3:2] address |
| wdata_i | input | 32 | Word to send on a write |
| trail_i | input | TRAIL_W | Idle slots after the data phase |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| swclk_o | output | 1 | Link clock |
| swdio_o | output | 1 | Link data driven by the host |
| swdio_oe | output | 1 | Host drives the link data when 1 |
| swdio_i | input | 1 | Link data as seen on the wire |
| rdata_o | output | 32 | Word received on a read |
| ack_o | output | 3 | Acknowledge as assembled |
| status_o | output | 2 | 0 OK, 1 WAIT, 2 FAULT |
| parity_err_o | output | 1 | Read parity mismatch |

## Verification
Reads are run with a clean word and with a deliberately wrong parity bit. This separates the data path from the parity check. Writes are run with two different words and with zero and non-zero idle counts. These show the data order, the write parity and whether the idle-slot branch is skipped. WAIT, a plain FAULT code and an all-ones acknowledge show that only the exact OK and WAIT codes open a data phase. A start pulse raised in the middle of a transfer shows that an extra request leaves the waveform unchanged and starts nothing afterwards.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HEADER,
        S_TURN_IN,
        S_ACK_IN,
        S_READ_DATA,
        S_TURN_OUT,
        S_WRITE_DATA,
        S_WAIT_IDLE,
        S_TRAILING,
        S_FINISH
    } xfer_state_t;

    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_WAIT  = 2'd1,
        XS_FAULT = 2'd2
    } xfer_status_t;

    localparam logic [2:0] ACK_CODE_OK   = 3'b001;
    localparam logic [2:0] ACK_CODE_WAIT = 3'b010;

    // Maps a raw acknowledge code onto the reported status.
    function automatic xfer_status_t classify_ack(input logic [2:0] code);
        xfer_status_t r;
        case (code)
            ACK_CODE_OK:   r = XS_OK;
            ACK_CODE_WAIT: r = XS_WAIT;
            default:       r = XS_FAULT;
        endcase
        return r;
    endfunction

    // Header bits, index 0 goes on the wire first.
    function automatic logic [7:0] build_header(input logic [3:0] rq);
        return {1'b1, 1'b0, ^rq, rq[3], rq[2], rq[1], rq[0], 1'b1};
    endfunction

endpackage

// File: rtl/swd_half_timer.sv
module swd_half_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic phase_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          last;

    assign last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (last) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_o = phase_q;
    assign rise_o  = run_i & ~phase_q & last;
    assign fall_o  = run_i &  phase_q & last;

    // R2: a rising transition can never be followed directly by another one
    a_r2_no_back_to_back_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture
    import swd_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ack_take_i,
    input  logic              data_take_i,
    input  logic              par_take_i,
    input  logic [4:0]        bit_idx_i,
    input  logic              din_i,
    output logic [2:0]        ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              perr_o
);
    logic [2:0]        ack_q;
    logic [DATA_W-1:0] word_q;
    logic              perr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ack_q  <= '0;
            word_q <= '0;
            perr_q <= 1'b0;
        end else begin
            if (ack_take_i)
                ack_q <= {ack_q[1:0], din_i};
            if (data_take_i)
                word_q[bit_idx_i] <= din_i;
            if (par_take_i)
                perr_q <= din_i ^ (^word_q);
        end
    end

    assign ack_o   = ack_q;
    assign rdata_o = word_q;
    assign perr_o  = perr_q;

    // R5: the parity flag only rises on the parity slot
    a_r5_perr_from_parity_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_q) |-> $past(par_take_i));

endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
    import swd_xfer_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int TRAIL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [3:0]         req_i,
    input  logic [31:0]        wdata_i,
    input  logic [TRAIL_W-1:0] trail_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               swclk_o,
    output logic               swdio_o,
    output logic               swdio_oe,
    input  logic               swdio_i,
    output logic [31:0]        rdata_o,
    output logic [2:0]         ack_o,
    output logic [1:0]         status_o,
    output logic               parity_err_o
);
    localparam int CNT_W = (TRAIL_W > 6) ? TRAIL_W : 6;
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(2);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(1);

    xfer_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [3:0]        req_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TRAIL_W-1:0] trail_q;
    xfer_status_t      status_q;

    logic run, phase, rise, fall, accept;
    logic [7:0] header;
    logic [2:0] ack_w;
    xfer_state_t after_data;

    assign run    = (state_q != S_IDLE) && (state_q != S_FINISH);
    assign accept = (state_q == S_IDLE) && start_i;
    assign header = build_header(req_q);
    assign after_data = (trail_q == '0) ? S_FINISH : S_TRAILING;

    swd_half_timer #(.HALF_DIV(HALF_DIV)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .phase_o (phase),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    swd_rx_capture i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .ack_take_i  (rise && (state_q == S_ACK_IN)),
        .data_take_i (rise && (state_q == S_READ_DATA) && (cnt_q != WORD_LAST)),
        .par_take_i  (rise && (state_q == S_READ_DATA) && (cnt_q == WORD_LAST)),
        .bit_idx_i   (cnt_q[4:0]),
        .din_i       (swdio_i),
        .ack_o       (ack_w),
        .rdata_o     (rdata_o),
        .perr_o      (parity_err_o)
    );

    // State register and per-transfer latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            req_q    <= '0;
            wdata_q  <= '0;
            trail_q  <= '0;
            status_q <= XS_OK;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                req_q    <= req_i;
                wdata_q  <= wdata_i;
                trail_q  <= trail_i;
                status_q <= XS_OK;
            end else if (fall && (state_q == S_ACK_IN) && (cnt_q == ACK_LAST)) begin
                status_q <= classify_ack(ack_w);
            end
        end
    end

    // Next-state logic; slots end on the falling transition of the link clock
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_HEADER;
                    cnt_d   = '0;
                end
            end
            S_HEADER: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == HDR_LAST) begin
                        state_d = S_TURN_IN;
                        cnt_d   = '0;
                    end
                end
            end
            S_TURN_IN: begin
                if (fall) begin
                    state_d = S_ACK_IN;
                    cnt_d   = '0;
                end
            end
            S_ACK_IN: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == ACK_LAST) begin
                        cnt_d = '0;
                        unique case (classify_ack(ack_w))
                            XS_OK:   state_d = req_q[1] ? S_READ_DATA : S_TURN_OUT;
                            XS_WAIT: state_d = S_WAIT_IDLE;
                            default: state_d = S_FINISH;
                        endcase
                    end
                end
            end
            S_READ_DATA, S_WRITE_DATA: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == WORD_LAST) begin
                        state_d = after_data;
                        cnt_d   = '0;
                    end
                end
            end
            S_TURN_OUT: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == PAIR_LAST) begin
                        state_d = S_WRITE_DATA;
                        cnt_d   = '0;
                    end
                end
            end
            S_WAIT_IDLE: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == PAIR_LAST) begin
                        state_d = S_FINISH;
                        cnt_d   = '0;
                    end
                end
            end
            S_TRAILING: begin
                if (fall) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(trail_q) - 1'b1) begin
                        state_d = S_FINISH;
                        cnt_d   = '0;
                    end
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        swclk_o  = run & phase;
        busy_o   = run;
        done_o   = (state_q == S_FINISH);
        swdio_oe = 1'b0;
        swdio_o  = 1'b0;
        unique case (state_q)
            S_HEADER: begin
                swdio_oe = 1'b1;
                swdio_o  = header[cnt_q[2:0]];
            end
            S_WRITE_DATA: begin
                swdio_oe = 1'b1;
                swdio_o  = (cnt_q == WORD_LAST) ? ^wdata_q : wdata_q[cnt_q[4:0]];
            end
            default: begin
                swdio_oe = 1'b0;
                swdio_o  = 1'b0;
            end
        endcase
    end

    assign ack_o    = ack_w;
    assign status_o = status_q;

    // R2: data and its enable are stable across every rising link clock
    a_r2_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swclk_o) |-> ($stable(swdio_o) && $stable(swdio_oe)));

    // R1: the link clock only toggles inside a transaction
    a_r1_clock_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swclk_o) |-> busy_o);

    // R10: completion is a single-cycle pulse outside busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: an OK acknowledge at completion always reports OK status
    a_r9_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (ack_o == ACK_CODE_OK)) |-> (status_o == 2'd0));

endmodule

// File: tb/test_swd_xfer_engine.sv
`timescale 1ns/1ps
module test_swd_xfer_engine;

    localparam int H  = 2;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [3:0] req_i = '0;
    logic [31:0] wdata_i = '0;
    logic [TW-1:0] trail_i = '0;
    logic busy_o, done_o, swclk_o, swdio_o, swdio_oe;
    logic swdio_i = 1'b0;
    logic [31:0] rdata_o;
    logic [2:0] ack_o;
    logic [1:0] status_o;
    logic parity_err_o;

    always #10 clk = ~clk;

    swd_xfer_engine #(.HALF_DIV(H), .TRAIL_W(TW)) i_swd_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
        .wdata_i(wdata_i), .trail_i(trail_i), .busy_o(busy_o), .done_o(done_o),
        .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
        .rdata_o(rdata_o), .ack_o(ack_o), .status_o(status_o), .parity_err_o(parity_err_o)
    );

    typedef struct packed {
        logic       ck;
        logic       oe;
        logic       dout;
        logic       di;
        logic [3:0] tag;
    } ent_t;

    ent_t ref_q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0]  exp_status;
    logic [2:0]  exp_ack;
    logic [31:0] exp_rdata;
    logic        exp_perr;
    bit          exp_read_ok;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // One bit slot: H cycles low then H cycles high
    task automatic push_slot(input logic oe, input logic d, input logic di, input int tag);
        for (int k = 0; k < 2*H; k++) begin
            ent_t e;
            e.ck = (k >= H);
            e.oe = oe;
            e.dout = d;
            e.di = di;
            e.tag = 4'(tag);
            ref_q.push_back(e);
        end
    endtask

    // Reference waveform built from the requirements
    task automatic plan_xfer(input logic [3:0] rq, input logic [31:0] wd, input int trail,
                             input logic [2:0] av, input logic [31:0] rd, input bit badpar);
        logic [7:0] hb;
        hb = {1'b1, 1'b0, rq[0]^rq[1]^rq[2]^rq[3], rq[3], rq[2], rq[1], rq[0], 1'b1};
        ref_q.delete();
        for (int i = 0; i < 8; i++) push_slot(1'b1, hb[i], 1'b0, 3);     // R3
        push_slot(1'b0, 1'b0, 1'b0, 4);                                   // R4 turnaround
        for (int i = 0; i < 3; i++) push_slot(1'b0, 1'b0, av[2-i], 4);    // R4 ack, MSB first
        exp_ack = av;
        exp_perr = 1'b0;
        exp_read_ok = 0;
        if (av == 3'b001) begin
            exp_status = 2'd0;
            if (rq[1]) begin
                for (int i = 0; i < 32; i++) push_slot(1'b0, 1'b0, rd[i], 5);   // R5
                push_slot(1'b0, 1'b0, (^rd) ^ badpar, 5);
                exp_rdata = rd;
                exp_perr = badpar;
                exp_read_ok = 1;
            end else begin
                push_slot(1'b0, 1'b0, 1'b0, 6);                                 // R6
                push_slot(1'b0, 1'b0, 1'b0, 6);
                for (int i = 0; i < 32; i++) push_slot(1'b1, wd[i], ~wd[i], 6);
                push_slot(1'b1, ^wd, 1'b0, 6);
            end
            for (int i = 0; i < trail; i++) push_slot(1'b0, 1'b0, 1'b1, 7);     // R7
        end else if (av == 3'b010) begin
            exp_status = 2'd1;
            push_slot(1'b0, 1'b0, 1'b0, 8);                                     // R8
            push_slot(1'b0, 1'b0, 1'b0, 8);
        end else begin
            exp_status = 2'd2;                                                  // R9
        end
    endtask

    task automatic run_xfer(input logic [3:0] rq, input logic [31:0] wd, input int trail,
                            input logic [2:0] av, input logic [31:0] rd, input bit badpar,
                            input bit mid_start);
        int idx;
        bit bad;
        plan_xfer(rq, wd, trail, av, rd, badpar);
        @(negedge clk);
        req_i = rq;
        wdata_i = wd;
        trail_i = TW'(trail);
        start_i = 1'b1;
        @(negedge clk);
        idx = 0;
        while (ref_q.size() > 0) begin
            ent_t e;
            e = ref_q.pop_front();
            start_i = (mid_start && idx == 20);   // R10: ignored while busy
            swdio_i = e.di;
            bad = (swclk_o !== e.ck) || (swdio_oe !== e.oe) ||
                  (e.oe && (swdio_o !== e.dout)) || (busy_o !== 1'b1) || (done_o !== 1'b0);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL R%0d R2 cycle %0d actual clk=%b oe=%b do=%b busy=%b done=%b expected clk=%b oe=%b do=%b busy=1 done=0",
                         e.tag, idx, swclk_o, swdio_oe, swdio_o, busy_o, done_o, e.ck, e.oe, e.dout);
            end
            idx++;
            @(negedge clk);
        end
        start_i = 1'b0;
        swdio_i = 1'b0;
        check(done_o === 1'b1 && busy_o === 1'b0, "R10", "done pulse", {30'd0, done_o, busy_o}, 32'h2);
        check(ack_o === exp_ack, "R4", "ack", 32'(ack_o), 32'(exp_ack));
        check(status_o === exp_status, "R9", "status", 32'(status_o), 32'(exp_status));
        if (exp_read_ok) begin
            check(rdata_o === exp_rdata, "R5", "rdata", rdata_o, exp_rdata);
            check(parity_err_o === exp_perr, "R5", "parity_err", 32'(parity_err_o), 32'(exp_perr));
        end
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0 && swclk_o === 1'b0 && swdio_oe === 1'b0,
              "R10", "idle after done", {28'd0, done_o, busy_o, swclk_o, swdio_oe}, 32'h0);
        @(negedge clk);
        check(busy_o === 1'b0, "R10", "no restart", 32'(busy_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(swclk_o === 1'b0 && swdio_oe === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
              "R1", "reset outputs", {28'd0, swclk_o, swdio_oe, busy_o, done_o}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(swclk_o === 1'b0 && swdio_oe === 1'b0 && busy_o === 1'b0,
              "R1", "idle outputs", {29'd0, swclk_o, swdio_oe, busy_o}, 32'h0);

        run_xfer(4'b0010, 32'h0, 3, 3'b001, 32'hA5C3_1E70, 1'b0, 1'b0);  // R5 read ok
        run_xfer(4'b1011, 32'h0, 0, 3'b001, 32'h8000_0001, 1'b1, 1'b0);  // R5 bad parity, R7 zero trail
        run_xfer(4'b0100, 32'h5000_0000, 2, 3'b001, 32'h0, 1'b0, 1'b0);  // R6 write
        run_xfer(4'b1101, 32'hDEAD_BEEF, 0, 3'b001, 32'h0, 1'b0, 1'b1);  // R6 + R10 mid start
        run_xfer(4'b0011, 32'h0, 5, 3'b010, 32'h0, 1'b0, 1'b0);          // R8 wait
        run_xfer(4'b0110, 32'h1234_5678, 4, 3'b100, 32'h0, 1'b0, 1'b0);  // R9 fault
        run_xfer(4'b1010, 32'h0, 4, 3'b111, 32'hFFFF_FFFF, 1'b0, 1'b0);  // R9 all ones

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule